// File: doc/BRIEF.md
# Bit-Field Deposit and Extract Unit

This block is the shift-and-mask stage of a 64-bit integer datapath. Each accepted operation either lifts a field of `len` bits out of a source word, starting at bit `pos`, and right-aligns it with sign or zero fill, or places the low `len` bits of a value into a target word starting at bit `pos`. In deposit modes the value can come from the source operand or from a small sign-extended immediate. A single operation code selects among four modes, and the result appears on a registered output one cycle after the operation is presented.

Fixed shifts need no separate shifter. A left shift by `n` is a deposit-into-zero with `pos = n` and `len = 64 - n`. An arithmetic right shift by `n` is a signed extract with `pos = n` and `len = 64 - n`. A logical right shift is the unsigned form of that extract. A two-state output sequencer tracks whether the output register holds a fresh result. Its states are `OUT_IDLE` and `OUT_VALID`. It moves from `OUT_IDLE` to `OUT_VALID` on an accepted input, stays in `OUT_VALID` while inputs keep arriving, and returns to `OUT_IDLE` on a cycle without input.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is 1 in exactly those cycles that directly follow a clock edge at which `in_valid` was 1. The `result` then belongs to that input.
- R3: With `op = 2'b00` (deposit), result bit `pos+k` equals bit `k` of the deposit value for `k < len`. Every other result bit equals the same bit of `tgt`.
- R4: With `op = 2'b01` (deposit into zero), the result is the deposit of R3 with an all-zero target. `tgt` has no effect.
- R5: In the two deposit modes, `use_imm = 1` makes the deposit value the 8-bit `imm` sign-extended to 64 bits. Otherwise the value is `src`. In the extract modes `use_imm` and `imm` have no effect.
- R6: With `op = 2'b11` (unsigned extract), result bit `k` equals `src[pos+k]` for `k` below the effective length. All higher result bits are 0.
- R7: With `op = 2'b10` (signed extract), the field is taken as in R6. The higher result bits are copies of the field's top bit.
- R8: Field bits that would lie above bit 63 are dropped. For extract, the effective length is `min(len, 64 - pos)`, and the signed form takes its fill bit from `src[63]` in that case.
- R9: Deposit-into-zero with `pos = n`, `len = 64 - n` equals `src << n`. Signed extract with the same operands equals an arithmetic right shift by `n`. Unsigned extract equals a logical right shift.
- R10: When `in_valid` is 0 at a clock edge, `result` keeps its value, whatever the other inputs do.
- R11: `len` values above 64 act as 64. `len = 0` is an empty field, so deposit returns `tgt`, deposit into zero returns 0, and both extracts return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 deposit, 01 deposit into zero, 10 signed extract, 11 unsigned extract |
| use_imm | input | 1 | Deposit value taken from sign-extended `imm` |
| src | input | 64 | Source operand |
| tgt | input | 64 | Target word for deposit |
| imm | input | 8 | Signed immediate deposit value |
| pos | input | 6 | Field start bit, 0 to 63 |
| len | input | 7 | Field length, 1 to 64 (see R11) |
| out_valid | output | 1 | `result` holds the outcome of the previous cycle's operation |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly one rising edge after the input cycle, and `out_valid` falls one edge after the first idle input cycle. The bench drives inputs at a falling edge and holds them through one rising edge. It deasserts `in_valid` at the next falling edge and samples `result` and `out_valid` at that moment, half a period after the register has updated. Hold checks sample further falling edges while the operands change with `in_valid` low. Back-to-back checks sample once per cycle, each against the input presented one edge earlier.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [1:0] {
        OP_DEP  = 2'b00,
        OP_DEPZ = 2'b01,
        OP_EXTS = 2'b10,
        OP_EXTU = 2'b11
    } bfu_op_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_VALID = 1'b1
    } out_state_e;

endpackage

// File: rtl/bfu_mask_gen.sv
// Low-order run of ones whose length is the requested field length, saturated at W.
module bfu_mask_gen #(
    parameter int W     = 64,
    parameter int LEN_W = $clog2(W) + 1
) (
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     mask
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(W);

    logic [LEN_W-1:0] eff;

    always_comb begin
        eff = (len > FULL) ? FULL : len;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = (LEN_W'(i) < eff);
    end
endmodule

// File: rtl/bfu_extract.sv
// Right-aligns a field, then fills the bits above it with zero or the field's top bit.
module bfu_extract #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W),
    parameter int LEN_W = POS_W + 1
) (
    input  logic [W-1:0]     src,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    input  logic             sign_fill,
    output logic [W-1:0]     res
);
    logic [W-1:0]     shifted;
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] eff;
    logic [W-1:0]     mask;
    logic             top_bit;

    always_comb begin
        shifted = src >> pos;
        room    = LEN_W'(W) - {1'b0, pos};
        eff     = (len < room) ? len : room;
    end

    bfu_mask_gen #(.W(W), .LEN_W(LEN_W)) u_mask (
        .len  (eff),
        .mask (mask)
    );

    always_comb begin
        if (eff == '0) begin
            top_bit = 1'b0;
        end else begin
            top_bit = shifted[POS_W'(eff - LEN_W'(1))];
        end
        res = (shifted & mask) | ((sign_fill && top_bit) ? ~mask : '0);
    end
endmodule

// File: rtl/bfu_deposit.sv
// Merges the low field of a value into a base word at a bit offset.
module bfu_deposit #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W),
    parameter int LEN_W = POS_W + 1
) (
    input  logic [W-1:0]     value,
    input  logic [W-1:0]     base,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     res
);
    logic [W-1:0] mask;
    logic [W-1:0] place_mask;
    logic [W-1:0] placed;

    bfu_mask_gen #(.W(W), .LEN_W(LEN_W)) u_mask (
        .len  (len),
        .mask (mask)
    );

    always_comb begin
        place_mask = mask << pos;
        placed     = (value & mask) << pos;
        res        = (base & ~place_mask) | placed;
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
    parameter int W     = 64,
    parameter int IMM_W = 8,
    parameter int POS_W = $clog2(W),
    parameter int LEN_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic             use_imm,
    input  logic [W-1:0]     src,
    input  logic [W-1:0]     tgt,
    input  logic [IMM_W-1:0] imm,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    output logic             out_valid,
    output logic [W-1:0]     result
);
    import bfu_pkg::*;

    bfu_op_e      op_e;
    logic [W-1:0] imm_ext;
    logic [W-1:0] dep_value;
    logic [W-1:0] dep_base;
    logic [W-1:0] dep_res;
    logic [W-1:0] ext_res;
    logic [W-1:0] next_res;

    out_state_e   state_q;
    out_state_e   state_d;

    // Operand selection
    always_comb begin
        op_e      = bfu_op_e'(op);
        imm_ext   = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
        dep_value = use_imm ? imm_ext : src;
        dep_base  = (op_e == OP_DEPZ) ? '0 : tgt;
    end

    bfu_deposit #(.W(W), .POS_W(POS_W), .LEN_W(LEN_W)) u_dep (
        .value (dep_value),
        .base  (dep_base),
        .pos   (pos),
        .len   (len),
        .res   (dep_res)
    );

    bfu_extract #(.W(W), .POS_W(POS_W), .LEN_W(LEN_W)) u_ext (
        .src       (src),
        .pos       (pos),
        .len       (len),
        .sign_fill (op_e == OP_EXTS),
        .res       (ext_res)
    );

    always_comb begin
        unique case (op_e)
            OP_DEP, OP_DEPZ: next_res = dep_res;
            OP_EXTS, OP_EXTU: next_res = ext_res;
            default:          next_res = '0;
        endcase
    end

    // Output sequencer: next state
    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = in_valid ? OUT_VALID : OUT_IDLE;
            OUT_VALID: state_d = in_valid ? OUT_VALID : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_res;
        end
    end

    assign out_valid = (state_q == OUT_VALID);
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
    parameter int W     = 64,
    parameter int POS_W = $clog2(W),
    parameter int LEN_W = POS_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op,
    input logic [W-1:0]     src,
    input logic [W-1:0]     tgt,
    input logic [POS_W-1:0] pos,
    input logic [LEN_W-1:0] len,
    input logic             out_valid,
    input logic [W-1:0]     result
);
    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2

    AST_INPUT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R10

    AST_DEPZ_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01 && len == '0) |=> (result == '0)); // R4

    AST_DEP_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && len == '0) |=> (result == $past(tgt))); // R11

    AST_EXT_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1] && len == '0) |=> (result == '0)); // R11

    AST_EXTU_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11 && pos == '0 && len >= LEN_W'(W)) |=> (result == $past(src))); // R6
endmodule

bind bitfield_unit bfu_checker #(.W(W), .POS_W(POS_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src       (src),
    .tgt       (tgt),
    .pos       (pos),
    .len       (len),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        use_imm = 1'b0;
    logic [63:0] src = '0;
    logic [63:0] tgt = '0;
    logic [7:0]  imm = '0;
    logic [5:0]  pos = '0;
    logic [6:0]  len = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
        .src(src), .tgt(tgt), .imm(imm), .pos(pos), .len(len),
        .out_valid(out_valid), .result(result)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-by-bit model written from the requirements
    function automatic logic [63:0] model(input logic [1:0] o, input logic ui, input logic [63:0] s,
                                          input logic [63:0] t, input logic [7:0] im,
                                          input int p, input int l);
        logic [63:0] r;
        logic [63:0] v;
        int el;
        logic fill;
        el = (l > 64) ? 64 : l;
        if (o[1] == 1'b0) begin
            v = ui ? {{56{im[7]}}, im} : s;
            r = (o == 2'b01) ? 64'd0 : t;
            for (int k = 0; k < el; k++) begin
                if (p + k < 64) r[p+k] = v[k];
            end
        end else begin
            if (el > 64 - p) el = 64 - p;
            fill = (o == 2'b10 && el > 0) ? s[p+el-1] : 1'b0;
            for (int k = 0; k < 64; k++) begin
                r[k] = (k < el) ? s[p+k] : fill;
            end
        end
        return r;
    endfunction

    // Present one operation, return after the result is registered
    task automatic run_op(input logic [1:0] o, input logic ui, input logic [63:0] s,
                          input logic [63:0] t, input logic [7:0] im, input int p, input int l);
        @(negedge clk);
        in_valid = 1'b1; op = o; use_imm = ui; src = s; tgt = t; imm = im;
        pos = 6'(p); len = 7'(l);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic op_check(input string tag, input logic [1:0] o, input logic ui,
                            input logic [63:0] s, input logic [63:0] t, input logic [7:0] im,
                            input int p, input int l);
        run_op(o, ui, s, t, im, p, l);
        chk(tag, result, model(o, ui, s, t, im, p, l));
    endtask

    task automatic t_reset;
        chk("R1 result in reset", result, 64'd0);
        chk("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R1 result after reset", result, 64'd0);
    endtask

    task automatic t_deposit;
        op_check("R3 deposit mid", 2'b00, 1'b0, 64'h0000_0000_0000_00AB, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, 12, 8);
        chk("R3 deposit literal", result, 64'hFFFF_FFFF_FFFA_BFFF);
        op_check("R3 deposit low", 2'b00, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hA5A5_A5A5_A5A5_A5A5, 8'h0, 0, 20);
        op_check("R3 deposit full", 2'b00, 1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1111_2222_3333_4444, 8'h0, 0, 64);
    endtask

    task automatic t_depz;
        op_check("R4 depz", 2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_DEAD_BEEF, 8'h0, 8, 4);
        chk("R4 depz literal", result, 64'h0000_0000_0000_0F00);
    endtask

    task automatic t_imm;
        op_check("R5 imm negative", 2'b00, 1'b1, 64'h0, 64'h0, 8'h80, 4, 16);
        chk("R5 imm literal", result, 64'h0000_0000_000F_F800);
        op_check("R5 imm positive depz", 2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h05, 60, 4);
        op_check("R5 imm ignored in extract", 2'b11, 1'b1, 64'h0000_0000_00C0_0000, 64'h0, 8'hFF, 20, 8);
        chk("R5 imm ignored literal", result, 64'h0000_0000_0000_000C);
    endtask

    task automatic t_extract;
        op_check("R6 extu", 2'b11, 1'b0, 64'hFEDC_BA98_7654_3210, 64'h0, 8'h0, 16, 12);
        chk("R6 extu literal", result, 64'h0000_0000_0000_0654);
        op_check("R6 extu whole", 2'b11, 1'b0, 64'h8000_0000_0000_0001, 64'h0, 8'h0, 0, 64);
        op_check("R7 exts negative", 2'b10, 1'b0, 64'h0000_0000_0000_0F00, 64'h0, 8'h0, 8, 4);
        chk("R7 exts literal", result, 64'hFFFF_FFFF_FFFF_FFFF);
        op_check("R7 exts positive", 2'b10, 1'b0, 64'h0000_0000_0000_0700, 64'h0, 8'h0, 8, 4);
    endtask

    task automatic t_trunc;
        op_check("R8 deposit truncated", 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h0, 60, 16);
        chk("R8 deposit literal", result, 64'hF000_0000_0000_0000);
        op_check("R8 exts truncated", 2'b10, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 8'h0, 62, 10);
        chk("R8 exts literal", result, 64'hFFFF_FFFF_FFFF_FFFE);
        op_check("R8 extu truncated", 2'b11, 1'b0, 64'hC000_0000_0000_0000, 64'h0, 8'h0, 62, 10);
    endtask

    task automatic t_shifts;
        logic [63:0] v;
        v = 64'h9234_5678_9ABC_DEF1;
        for (int n = 1; n < 64; n += 13) begin
            run_op(2'b01, 1'b0, v, 64'h0, 8'h0, n, 64 - n);
            chk("R9 shift left", result, v << n);
            run_op(2'b10, 1'b0, v, 64'h0, 8'h0, n, 64 - n);
            chk("R9 arith right", result, 64'($signed(v) >>> n));
            run_op(2'b11, 1'b0, v, 64'h0, 8'h0, n, 64 - n);
            chk("R9 logic right", result, v >> n);
        end
    endtask

    task automatic t_hold;
        logic [63:0] kept;
        run_op(2'b11, 1'b0, 64'h0000_0000_1234_0000, 64'h0, 8'h0, 16, 16);
        kept = result;
        chk("R2 valid one cycle after", {63'd0, out_valid}, 64'd1);
        op = 2'b01; src = 64'hFFFF_FFFF_FFFF_FFFF; pos = 6'd0; len = 7'd64;
        @(negedge clk);
        chk("R2 valid drops", {63'd0, out_valid}, 64'd0);
        chk("R10 result held", result, kept);
        tgt = 64'h5555_5555_5555_5555; op = 2'b00;
        @(negedge clk);
        chk("R10 result held later", result, kept);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; op = 2'b11; use_imm = 1'b0; src = 64'h00FF; pos = 6'd0; len = 7'd4;
        @(negedge clk);
        chk("R2 b2b first", result, 64'h000F);
        chk("R2 b2b valid", {63'd0, out_valid}, 64'd1);
        op = 2'b01; src = 64'h3; pos = 6'd4; len = 7'd2;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second", result, 64'h0030);
        chk("R2 b2b still valid", {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_len_edges;
        op_check("R11 deposit len0", 2'b00, 1'b0, 64'hFFFF, 64'h1234_5678_9ABC_DEF0, 8'h0, 4, 0);
        chk("R11 deposit len0 literal", result, 64'h1234_5678_9ABC_DEF0);
        op_check("R11 depz len0", 2'b01, 1'b0, 64'hFFFF, 64'h1, 8'h0, 4, 0);
        op_check("R11 exts len0", 2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h0, 3, 0);
        chk("R11 exts len0 literal", result, 64'h0);
        op_check("R11 len above 64", 2'b11, 1'b0, 64'hA000_0000_0000_0005, 64'h0, 8'h0, 0, 100);
        chk("R11 len above 64 literal", result, 64'hA000_0000_0000_0005);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_deposit();
        t_depz();
        t_imm();
        t_extract();
        t_trunc();
        t_shifts();
        t_hold();
        t_back_to_back();
        t_len_edges();
        @(negedge clk);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule